// File: doc/BRIEF.md
# Interrupt Aggregation and Deassertion Controller

This block gathers a vector of event inputs into a sticky status word, gates that word with a per-source enable word, and ORs the result into one master interrupt. The master interrupt drives a single request pin. Software chooses the pin's active level and whether it behaves as a push-pull driver or as an emulated open-drain driver, using an output-enable.

After the pin leaves its active state, a hold-off counter starts. It counts a programmable number of external ticks, and the pin cannot become active again until the count is complete. Software can see that the hold-off is running, can cut it short with a clear command, or can set the interval to zero so that no hold-off occurs.

Access goes through a small register port with three words: configuration, status and enable. Reads are combinational. Writes take effect at the clock edge. The top source bit is a software interrupt, and software raises it through the enable word.

Top module: `irq_combiner`

## Requirements
- R1: After reset, the configuration, status and enable words all read zero. With the zero configuration (open-drain, active-low), `irq_oe` is 0 and `irq_out` is 0.
- R2: A status bit becomes 1 in the cycle after its `event_in` bit is high, and it stays 1. When a set and a clear land on the same bit in the same cycle, the set wins.
- R3: Writing the status word (`reg_sel`=1) clears every bit written as 1. Bits written as 0 keep their value.
- R4: Configuration bit 12 reads the OR of (status AND enable), whatever the value of configuration bit 8.
- R5: The internal active state becomes 1 one clock after all of these hold: configuration bit 8 is 1, the master interrupt is 1, and no hold-off is running. It becomes 0 one clock after any of them stops holding.
- R6: Configuration bit 4 sets the active level: 1 makes `irq_out` high when active, 0 makes it low when active.
- R7: When configuration bit 0 is 1 (push-pull), `irq_oe` is always 1 and `irq_out` carries the inactive level while inactive. When bit 0 is 0 (open-drain), `irq_oe` follows the active state and `irq_out` carries the active level.
- R8: When the active state falls, a counter loads the interval in configuration bits 31:24 and counts down once per `tick` pulse. While it is nonzero, configuration bit 13 reads 1 and the pin cannot become active again.
- R9: An interval of 0 gives no hold-off. The pin can become active again in the next eligible cycle.
- R10: A configuration write with bit 14 set clears the hold-off counter. Bit 14 always reads 0, and the clear takes priority over a load in the same cycle.
- R11: Writing the enable word (`reg_sel`=2) with bit 31 set also sets status bit 31, the software interrupt.
- R12: The enable word reads back exactly the value written.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| event_in | input | 32 | Event inputs, one per status bit |
| tick | input | 1 | One-cycle pulse for each hold-off time unit |
| reg_sel | input | 2 | Word select: 0 configuration, 1 status, 2 enable |
| reg_wr | input | 1 | Write strobe |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Read data for the selected word |
| irq_out | output | 1 | Interrupt pin value |
| irq_oe | output | 1 | Interrupt pin output-enable |

## Verification
The hardest state to reach from the ports is a pending interrupt that is blocked only by a running hold-off. To get there, the stimulus raises the pin, clears the source so the pin falls and the counter loads, and then pulses the event again while the counter is still running. From that state, ticks are issued one at a time to find the exact edge at which the pin comes back. A second pass reaches the same state and ends it with the clear command instead of ticks.

// File: rtl/irq_combiner_pkg.sv
package irq_combiner_pkg;

    localparam int DATA_W   = 32;
    localparam int IVL_W    = 8;

    // configuration word bit positions
    localparam int CFG_IVL_LSB = 24;
    localparam int CFG_CLR_BIT = 14;
    localparam int CFG_RUN_BIT = 13;
    localparam int CFG_MST_BIT = 12;
    localparam int CFG_DRV_BIT = 8;
    localparam int CFG_POL_BIT = 4;
    localparam int CFG_PP_BIT  = 0;

    typedef enum logic [1:0] {
        SEL_CFG    = 2'd0,
        SEL_STATUS = 2'd1,
        SEL_ENABLE = 2'd2,
        SEL_NONE   = 2'd3
    } reg_sel_e;

    typedef struct packed {
        logic [IVL_W-1:0] interval;
        logic             drive_en;
        logic             pol_high;
        logic             push_pull;
    } cfg_t;

    function automatic cfg_t cfg_from_word(input logic [DATA_W-1:0] w);
        cfg_t c;
        c.interval  = w[CFG_IVL_LSB +: IVL_W];
        c.drive_en  = w[CFG_DRV_BIT];
        c.pol_high  = w[CFG_POL_BIT];
        c.push_pull = w[CFG_PP_BIT];
        return c;
    endfunction

    function automatic logic [DATA_W-1:0] cfg_to_word(input cfg_t c,
                                                      input logic running,
                                                      input logic master);
        logic [DATA_W-1:0] w;
        w = '0;
        w[CFG_IVL_LSB +: IVL_W] = c.interval;
        w[CFG_RUN_BIT] = running;
        w[CFG_MST_BIT] = master;
        w[CFG_DRV_BIT] = c.drive_en;
        w[CFG_POL_BIT] = c.pol_high;
        w[CFG_PP_BIT]  = c.push_pull;
        return w;
    endfunction

endpackage

// File: rtl/irq_src_bank.sv
module irq_src_bank #(
    parameter int NSRC = 32
) (
    input  logic            clk,
    input  logic            rst,
    input  logic [NSRC-1:0] event_in,
    input  logic            stat_wr,
    input  logic            en_wr,
    input  logic [NSRC-1:0] wdata,
    output logic [NSRC-1:0] status_q,
    output logic [NSRC-1:0] enable_q,
    output logic            master
);
    localparam int SW_BIT = NSRC - 1;

    logic [NSRC-1:0] clr_mask;
    logic [NSRC-1:0] sw_set;

    always_comb begin
        clr_mask = stat_wr ? wdata : '0;
        sw_set   = '0;
        sw_set[SW_BIT] = en_wr & wdata[SW_BIT];
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            status_q <= '0;
            enable_q <= '0;
        end else begin
            status_q <= (status_q & ~clr_mask) | event_in | sw_set;
            if (en_wr)
                enable_q <= wdata;
        end
    end

    assign master = |(status_q & enable_q);
endmodule

// File: rtl/irq_holdoff.sv
module irq_holdoff #(
    parameter int IW = 8
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          tick,
    input  logic          load,
    input  logic          clr,
    input  logic [IW-1:0] interval,
    output logic [IW-1:0] cnt,
    output logic          running
);
    always_ff @(posedge clk) begin
        if (rst)
            cnt <= '0;
        else if (clr)
            cnt <= '0;
        else if (load)
            cnt <= interval;
        else if (tick && cnt != '0)
            cnt <= cnt - 1'b1;
    end

    assign running = (cnt != '0);
endmodule

// File: rtl/irq_pin_drv.sv
module irq_pin_drv (
    input  logic clk,
    input  logic rst,
    input  logic want,
    input  logic pol_high,
    input  logic push_pull,
    output logic active,
    output logic fell,
    output logic irq_out,
    output logic irq_oe
);
    always_ff @(posedge clk) begin
        if (rst)
            active <= 1'b0;
        else
            active <= want;
    end

    assign fell = active & ~want;

    always_comb begin
        if (push_pull) begin
            irq_oe  = 1'b1;
            irq_out = active ? pol_high : ~pol_high;
        end else begin
            irq_oe  = active;
            irq_out = pol_high;
        end
    end
endmodule

// File: rtl/irq_combiner.sv
module irq_combiner
    import irq_combiner_pkg::*;
#(
    parameter int NSRC = 32
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [NSRC-1:0]   event_in,
    input  logic              tick,
    input  logic [1:0]        reg_sel,
    input  logic              reg_wr,
    input  logic [DATA_W-1:0] reg_wdata,
    output logic [DATA_W-1:0] reg_rdata,
    output logic              irq_out,
    output logic              irq_oe
);
    cfg_t             cfg_q;
    logic [NSRC-1:0]  status_q;
    logic [NSRC-1:0]  enable_q;
    logic             master;
    logic [IVL_W-1:0] hold_cnt;
    logic             running;
    logic             irq_active;
    logic             fell;
    logic             cfg_wr;
    logic             hold_clr;
    logic             want;

    assign cfg_wr   = reg_wr && (reg_sel == SEL_CFG);
    assign hold_clr = cfg_wr && reg_wdata[CFG_CLR_BIT];

    always_ff @(posedge clk) begin
        if (rst)
            cfg_q <= '0;
        else if (cfg_wr)
            cfg_q <= cfg_from_word(reg_wdata);
    end

    irq_src_bank #(.NSRC(NSRC)) u_bank (
        .clk      (clk),
        .rst      (rst),
        .event_in (event_in),
        .stat_wr  (reg_wr && (reg_sel == SEL_STATUS)),
        .en_wr    (reg_wr && (reg_sel == SEL_ENABLE)),
        .wdata    (reg_wdata[NSRC-1:0]),
        .status_q (status_q),
        .enable_q (enable_q),
        .master   (master)
    );

    assign want = cfg_q.drive_en & master & ~running;

    irq_holdoff #(.IW(IVL_W)) u_hold (
        .clk      (clk),
        .rst      (rst),
        .tick     (tick),
        .load     (fell),
        .clr      (hold_clr),
        .interval (cfg_q.interval),
        .cnt      (hold_cnt),
        .running  (running)
    );

    irq_pin_drv u_pin (
        .clk       (clk),
        .rst       (rst),
        .want      (want),
        .pol_high  (cfg_q.pol_high),
        .push_pull (cfg_q.push_pull),
        .active    (irq_active),
        .fell      (fell),
        .irq_out   (irq_out),
        .irq_oe    (irq_oe)
    );

    always_comb begin
        unique case (reg_sel)
            SEL_CFG:    reg_rdata = cfg_to_word(cfg_q, running, master);
            SEL_STATUS: reg_rdata = DATA_W'(status_q);
            SEL_ENABLE: reg_rdata = DATA_W'(enable_q);
            default:    reg_rdata = '0;
        endcase
    end
endmodule

// File: rtl/irq_combiner_checker.sv
module irq_combiner_checker #(
    parameter int NSRC = 32,
    parameter int IW   = 8
) (
    input logic            clk,
    input logic            rst,
    input logic [NSRC-1:0] event_in,
    input logic [1:0]      reg_sel,
    input logic            reg_wr,
    input logic [31:0]     reg_wdata,
    input logic [NSRC-1:0] status_q,
    input logic [IW-1:0]   hold_cnt,
    input logic            irq_active,
    input logic            drive_en,
    input logic            pol_high,
    input logic            push_pull,
    input logic            irq_out,
    input logic            irq_oe
);
    assert_sticky_R2: assert property (@(posedge clk) disable iff (rst)
        (!rst && event_in != '0) |=> ((status_q & $past(event_in)) == $past(event_in)));

    assert_w1c_R3: assert property (@(posedge clk) disable iff (rst)
        (!rst && reg_wr && reg_sel == 2'd1 && event_in == '0)
        |=> (status_q == ($past(status_q) & ~$past(reg_wdata[NSRC-1:0]))));

    assert_active_needs_drive_R5: assert property (@(posedge clk) disable iff (rst)
        irq_active |-> $past(drive_en));

    assert_active_level_R6: assert property (@(posedge clk) disable iff (rst)
        (irq_active && irq_oe) |-> (irq_out == pol_high));

    assert_pushpull_oe_R7: assert property (@(posedge clk) disable iff (rst)
        push_pull |-> irq_oe);

    assert_opendrain_release_R7: assert property (@(posedge clk) disable iff (rst)
        (!push_pull && !irq_active) |-> !irq_oe);

    assert_no_active_in_holdoff_R8: assert property (@(posedge clk) disable iff (rst)
        irq_active |-> (hold_cnt == '0));
endmodule

bind irq_combiner irq_combiner_checker #(.NSRC(NSRC), .IW(irq_combiner_pkg::IVL_W)) u_chk (
    .clk        (clk),
    .rst        (rst),
    .event_in   (event_in),
    .reg_sel    (reg_sel),
    .reg_wr     (reg_wr),
    .reg_wdata  (reg_wdata),
    .status_q   (status_q),
    .hold_cnt   (hold_cnt),
    .irq_active (irq_active),
    .drive_en   (cfg_q.drive_en),
    .pol_high   (cfg_q.pol_high),
    .push_pull  (cfg_q.push_pull),
    .irq_out    (irq_out),
    .irq_oe     (irq_oe)
);

// File: tb/irq_combiner_test.sv
module irq_combiner_test;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [31:0] event_in = '0;
    logic        tick = 1'b0;
    logic [1:0]  reg_sel = '0;
    logic        reg_wr = 1'b0;
    logic [31:0] reg_wdata = '0;
    logic [31:0] reg_rdata;
    logic        irq_out;
    logic        irq_oe;

    int checks = 0;
    int errors = 0;
    bit done = 0;

    localparam logic [31:0] DRV = 32'h0000_0100;
    localparam logic [31:0] POL = 32'h0000_0010;
    localparam logic [31:0] PP  = 32'h0000_0001;
    localparam logic [31:0] CLR = 32'h0000_4000;
    localparam logic [31:0] RUN = 32'h0000_2000;
    localparam logic [31:0] MST = 32'h0000_1000;

    always #2 clk = ~clk;

    irq_combiner uut (
        .clk(clk), .rst(rst), .event_in(event_in), .tick(tick),
        .reg_sel(reg_sel), .reg_wr(reg_wr), .reg_wdata(reg_wdata),
        .reg_rdata(reg_rdata), .irq_out(irq_out), .irq_oe(irq_oe)
    );

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [1:0] sel, input logic [31:0] d);
        @(negedge clk);
        reg_sel = sel; reg_wdata = d; reg_wr = 1'b1;
        @(negedge clk);
        reg_wr = 1'b0; reg_wdata = '0;
    endtask

    task automatic rd(input logic [1:0] sel, output logic [31:0] d);
        reg_sel = sel;
        #0.5;
        d = reg_rdata;
    endtask

    task automatic pulse_event(input logic [31:0] e);
        @(negedge clk);
        event_in = e;
        @(negedge clk);
        event_in = '0;
    endtask

    task automatic pulse_tick();
        @(negedge clk);
        tick = 1'b1;
        @(negedge clk);
        tick = 1'b0;
    endtask

    task automatic t_reset();
        logic [31:0] v;
        rd(2'd0, v); check("R1 cfg", v, 32'h0);
        rd(2'd1, v); check("R1 status", v, 32'h0);
        rd(2'd2, v); check("R1 enable", v, 32'h0);
        check("R1 oe", {31'b0, irq_oe}, 32'h0);
        check("R1 out", {31'b0, irq_out}, 32'h0);
    endtask

    task automatic t_sticky_w1c();
        logic [31:0] v;
        pulse_event(32'h0000_0008);
        rd(2'd1, v); check("R2 sticky single", v, 32'h0000_0008);
        pulse_event(32'h0000_0080);
        rd(2'd1, v); check("R2 sticky accumulate", v, 32'h0000_0088);
        wr(2'd1, 32'h0000_0080);
        rd(2'd1, v); check("R3 w1c one bit", v, 32'h0000_0008);
        wr(2'd1, 32'h0);
        rd(2'd1, v); check("R3 write zero no effect", v, 32'h0000_0008);
        @(negedge clk);
        event_in = 32'h0000_0008; reg_sel = 2'd1; reg_wdata = 32'h0000_0008; reg_wr = 1'b1;
        @(negedge clk);
        event_in = '0; reg_wr = 1'b0; reg_wdata = '0;
        rd(2'd1, v); check("R2 set beats clear", v, 32'h0000_0008);
        wr(2'd1, 32'hFFFF_FFFF);
        rd(2'd1, v); check("R3 clear all", v, 32'h0);
    endtask

    task automatic t_master_pins();
        logic [31:0] v;
        wr(2'd2, 32'h0000_0010);
        rd(2'd2, v); check("R12 enable readback", v, 32'h0000_0010);
        pulse_event(32'h0000_0010);
        @(negedge clk);
        rd(2'd0, v); check("R4 master w/o drive", v, MST);
        check("R5 no drive -> od released", {31'b0, irq_oe}, 32'h0);
        wr(2'd0, DRV | POL | PP);
        @(negedge clk);
        check("R6 pp active high out", {31'b0, irq_out}, 32'h1);
        check("R7 pp oe", {31'b0, irq_oe}, 32'h1);
        wr(2'd1, 32'h0000_0010);
        @(negedge clk);
        check("R7 pp inactive low", {30'b0, irq_oe, irq_out}, 32'h2);
        wr(2'd0, DRV | PP);
        @(negedge clk);
        check("R6 pp active-low idle", {31'b0, irq_out}, 32'h1);
        pulse_event(32'h0000_0010);
        @(negedge clk);
        check("R6 pp active-low asserted", {31'b0, irq_out}, 32'h0);
        wr(2'd0, DRV | POL);
        @(negedge clk);
        check("R7 od driven while active", {30'b0, irq_oe, irq_out}, 32'h3);
        wr(2'd1, 32'h0000_0010);
        @(negedge clk);
        check("R7 od released", {31'b0, irq_oe}, 32'h0);
    endtask

    task automatic t_holdoff();
        logic [31:0] v;
        logic [31:0] c;
        c = 32'h0300_0000 | DRV | POL | PP;
        wr(2'd0, c);
        pulse_event(32'h0000_0010);
        @(negedge clk);
        check("R8 asserted before holdoff", {31'b0, irq_out}, 32'h1);
        wr(2'd1, 32'h0000_0010);
        @(negedge clk);
        rd(2'd0, v);
        check("R8 running flag", v & RUN, RUN);
        check("R8 deasserted", {31'b0, irq_out}, 32'h0);
        pulse_event(32'h0000_0010);
        @(negedge clk);
        check("R8 blocked pending", {31'b0, irq_out}, 32'h0);
        pulse_tick();
        pulse_tick();
        @(negedge clk);
        rd(2'd0, v);
        check("R8 still running after 2 ticks", v & RUN, RUN);
        check("R8 still blocked", {31'b0, irq_out}, 32'h0);
        pulse_tick();
        rd(2'd0, v);
        check("R8 done after 3 ticks", v & RUN, 32'h0);
        check("R8 no early reassert", {31'b0, irq_out}, 32'h0);
        @(negedge clk);
        check("R8 reassert", {31'b0, irq_out}, 32'h1);
        // R10: clear command ends hold-off
        wr(2'd1, 32'h0000_0010);
        @(negedge clk);
        rd(2'd0, v);
        check("R10 holdoff started", v & RUN, RUN);
        pulse_event(32'h0000_0010);
        wr(2'd0, c | CLR);
        rd(2'd0, v);
        check("R10 counter cleared", v & RUN, 32'h0);
        check("R10 clear bit reads 0", v & CLR, 32'h0);
        @(negedge clk);
        check("R10 reassert after clear", {31'b0, irq_out}, 32'h1);
        // R9: zero interval
        wr(2'd0, DRV | POL | PP);
        wr(2'd1, 32'h0000_0010);
        @(negedge clk);
        rd(2'd0, v);
        check("R9 no running flag", v & RUN, 32'h0);
        check("R9 deasserted", {31'b0, irq_out}, 32'h0);
        pulse_event(32'h0000_0010);
        @(negedge clk);
        check("R9 immediate reassert", {31'b0, irq_out}, 32'h1);
        wr(2'd1, 32'hFFFF_FFFF);
        @(negedge clk);
    endtask

    task automatic t_swint();
        logic [31:0] v;
        wr(2'd2, 32'h8000_0010);
        rd(2'd1, v); check("R11 sw status set", v, 32'h8000_0000);
        rd(2'd2, v); check("R12 enable readback sw", v, 32'h8000_0010);
        @(negedge clk);
        check("R11 sw raises pin", {31'b0, irq_out}, 32'h1);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        t_reset();
        t_sticky_w1c();
        t_master_pins();
        t_holdoff();
        t_swint();
        done = 1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog: actual=hung expected=complete");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end
endmodule